// File: doc/BRIEF.md
# Secondary Cache Hit Claim Qualifier

This block sits inside a system bus memory controller and decides, for every address tenure, whether the controller's own memory cycle should run or whether an external secondary cache will serve the access. When the transaction start strobe is seen, the block classifies the transaction. If the transaction is not eligible for the cache, the block releases the memory access at once. If it is eligible, the block waits a programmable number of clocks. It then samples the cache's hit and retry inputs exactly once.

A sampled hit means the external cache answers the bus handshake itself, so the block pulses a claim indication and the memory controller stays quiet. A retry from the cache cancels the attempt outright. Otherwise the memory access is launched. Only one tenure is tracked at a time: a strobe that arrives while a decision is pending is parked in a single holding slot and handled once the pending decision is made.

Top module: `l2_claim_qual`

## Requirements
- R1: When `cfg_l2_present` is 0 at acceptance, `l2_hit` and `l2_retry` are ignored and `mem_start` pulses in the cycle after the accepting edge.
- R2: For an eligible transaction with `cfg_hit_delay` = d (0..3), the hit and retry inputs are sampled only at the clock edge d+1 cycles after the accepting edge; their values in any other cycle have no effect, and the verdict pulse appears in the following cycle.
- R3: A sampled hit without retry gives a one-cycle `l2_claimed` pulse and no `mem_start`.
- R4: A sampled miss without retry gives a one-cycle `mem_start` pulse.
- R5: When retry is sampled, alone or together with hit, `retried` pulses for one cycle and neither `mem_start` nor `l2_claimed` is raised.
- R6: A transaction with `txn_ci` = 1 is non-cachable: `mem_start` pulses in the cycle after acceptance and no sample window opens.
- R7: A transaction with `txn_internal` = 1 or `txn_local_bank` = 1 is non-cachable whatever its other attributes, and is handled as in R6.
- R8: A cachable transaction whose region is not a 64-bit port (`txn_port64` = 0) or has pipelining set (`txn_pipelined` = 1) raises `cfg_error` and `mem_start` together for one cycle after acceptance.
- R9: A start strobe seen while a sample window is open is held (one slot) and is accepted in the first idle cycle after the pending decision; its attributes are those present with its strobe.
- R10: At most one of `mem_start`, `l2_claimed`, `retried` is high in any cycle, and `busy` stays high for no more than 2^DLY_W consecutive cycles.
- R11: Synchronous active-high reset clears all outputs, the held strobe and any open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_l2_present | input | 1 | External secondary cache is fitted |
| cfg_hit_delay | input | DLY_W | Extra clocks before the hit sample point |
| ts | input | 1 | Transaction start strobe |
| txn_ci | input | 1 | Transaction is caching-inhibited |
| txn_internal | input | 1 | Transaction targets the internal register space |
| txn_local_bank | input | 1 | Transaction targets a local-bus bank |
| txn_port64 | input | 1 | Target region has a 64-bit port |
| txn_pipelined | input | 1 | Target region has data pipelining enabled |
| l2_hit | input | 1 | Hit response from the external cache |
| l2_retry | input | 1 | Retry response from the external cache |
| mem_start | output | 1 | One-cycle launch of the controller's memory access |
| l2_claimed | output | 1 | One-cycle indication that the external cache serves the access |
| retried | output | 1 | One-cycle indication that the attempt was retried |
| cfg_error | output | 1 | One-cycle flag for a cachable access to an unsuitable region |
| busy | output | 1 | A sample window is open |

## Verification
Two things can fall in one cycle here: the hit and retry responses at the sample edge, and a fresh start strobe arriving during an open window, which must be held while the current decision is taken. The bench drives retry and hit together at the sample point and expects only the retry pulse. It also fires a second strobe mid-window with different attributes and expects the first verdict followed one cycle later by the held transaction's own verdict. Noise on hit and retry outside the sample edge, including the inverse of the sampled value, shows that only the programmed edge counts.

// File: rtl/l2cq_pkg.sv
package l2cq_pkg;

    typedef struct packed {
        logic ci;
        logic intl;
        logic local_bank;
        logic port64;
        logic pipelined;
    } txn_attr_t;

    typedef enum logic [1:0] {
        ROUTE_MEM     = 2'd0,
        ROUTE_MEM_ERR = 2'd1,
        ROUTE_WAIT    = 2'd2
    } route_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    typedef struct packed {
        logic mem_start;
        logic claimed;
        logic retried;
        logic cfg_err;
    } verdict_t;

    localparam verdict_t VERDICT_NONE = '{default: 1'b0};

    function automatic logic f_cachable(input txn_attr_t a);
        return !(a.ci || a.intl || a.local_bank);
    endfunction

    function automatic logic f_region_ok(input txn_attr_t a);
        return a.port64 && !a.pipelined;
    endfunction

    function automatic route_e f_route(input logic present, input txn_attr_t a);
        route_e r;
        if (!present || !f_cachable(a))
            r = ROUTE_MEM;
        else if (!f_region_ok(a))
            r = ROUTE_MEM_ERR;
        else
            r = ROUTE_WAIT;
        return r;
    endfunction

    function automatic verdict_t f_sample(input logic hit, input logic retry);
        verdict_t v;
        v = VERDICT_NONE;
        if (retry)
            v.retried = 1'b1;
        else if (hit)
            v.claimed = 1'b1;
        else
            v.mem_start = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/l2cq_classify.sv
module l2cq_classify
    import l2cq_pkg::*;
(
    input  logic      present,
    input  txn_attr_t attr,
    output route_e    route
);
    always_comb begin
        route = f_route(present, attr);
    end
endmodule

// File: rtl/l2cq_delay_ctr.sv
module l2cq_delay_ctr #(
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/l2cq_hold_slot.sv
module l2cq_hold_slot
    import l2cq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  txn_attr_t push_attr,
    input  logic      pop,
    output logic      valid,
    output txn_attr_t attr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            attr  <= '0;
        end else if (push) begin
            valid <= 1'b1;
            attr  <= push_attr;
        end else if (pop) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/l2_claim_qual.sv
module l2_claim_qual
    import l2cq_pkg::*;
#(
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_l2_present,
    input  logic [DLY_W-1:0] cfg_hit_delay,
    input  logic             ts,
    input  logic             txn_ci,
    input  logic             txn_internal,
    input  logic             txn_local_bank,
    input  logic             txn_port64,
    input  logic             txn_pipelined,
    input  logic             l2_hit,
    input  logic             l2_retry,
    output logic             mem_start,
    output logic             l2_claimed,
    output logic             retried,
    output logic             cfg_error,
    output logic             busy
);
    state_e    state_q, state_d;
    verdict_t  verdict_q, verdict_d;
    txn_attr_t live_attr, hold_attr, src_attr;
    logic      hold_valid, hold_push, hold_pop;
    logic      accept, ctr_load, expired;
    route_e    route;

    assign live_attr = '{ci: txn_ci, intl: txn_internal, local_bank: txn_local_bank,
                         port64: txn_port64, pipelined: txn_pipelined};

    // A held strobe has priority over a live one in an idle cycle.
    assign accept    = (state_q == ST_IDLE) && (hold_valid || ts);
    assign src_attr  = hold_valid ? hold_attr : live_attr;
    assign hold_pop  = (state_q == ST_IDLE) && hold_valid;
    assign hold_push = ts && !((state_q == ST_IDLE) && !hold_valid);

    l2cq_hold_slot u_hold (
        .clk       (clk),
        .rst       (rst),
        .push      (hold_push),
        .push_attr (live_attr),
        .pop       (hold_pop),
        .valid     (hold_valid),
        .attr      (hold_attr)
    );

    l2cq_classify u_cls (
        .present (cfg_l2_present),
        .attr    (src_attr),
        .route   (route)
    );

    assign ctr_load = accept && (route == ROUTE_WAIT);

    l2cq_delay_ctr #(.DLY_W(DLY_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (cfg_hit_delay),
        .run      (state_q == ST_WAIT),
        .expired  (expired)
    );

    always_comb begin
        state_d   = state_q;
        verdict_d = VERDICT_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (route)
                        ROUTE_WAIT:    state_d = ST_WAIT;
                        ROUTE_MEM_ERR: begin
                            verdict_d.mem_start = 1'b1;
                            verdict_d.cfg_err   = 1'b1;
                        end
                        default:       verdict_d.mem_start = 1'b1;
                    endcase
                end
            end
            ST_WAIT: begin
                if (expired) begin
                    verdict_d = f_sample(l2_hit, l2_retry);
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            verdict_q <= VERDICT_NONE;
        end else begin
            state_q   <= state_d;
            verdict_q <= verdict_d;
        end
    end

    assign mem_start  = verdict_q.mem_start;
    assign l2_claimed = verdict_q.claimed;
    assign retried    = verdict_q.retried;
    assign cfg_error  = verdict_q.cfg_err;
    assign busy       = (state_q == ST_WAIT);
endmodule

// File: rtl/l2cq_checker.sv
module l2cq_checker #(
    parameter int DLY_W = 2
) (
    input logic clk,
    input logic rst,
    input logic l2_hit,
    input logic l2_retry,
    input logic mem_start,
    input logic l2_claimed,
    input logic retried,
    input logic cfg_error,
    input logic busy
);
    localparam int WIN_MAX = 1 << DLY_W;
    localparam int RUN_W   = DLY_W + 2;

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)
            busy_run <= '0;
        else if (busy)
            busy_run <= (busy_run == {RUN_W{1'b1}}) ? busy_run : busy_run + 1'b1;
        else
            busy_run <= '0;
    end

    a_r10_one_verdict: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_start, l2_claimed, retried}));

    a_r10_window_bound: assert property (@(posedge clk) disable iff (rst)
        busy_run <= RUN_W'(WIN_MAX));

    a_r3_claim_from_hit: assert property (@(posedge clk) disable iff (rst)
        l2_claimed |-> ($past(l2_hit) && !$past(l2_retry)));

    a_r5_retry_from_input: assert property (@(posedge clk) disable iff (rst)
        retried |-> $past(l2_retry));

    a_r8_error_goes_to_memory: assert property (@(posedge clk) disable iff (rst)
        cfg_error |-> mem_start);

    a_r3_claim_single_cycle: assert property (@(posedge clk) disable iff (rst)
        l2_claimed |=> !l2_claimed);
endmodule

bind l2_claim_qual l2cq_checker #(.DLY_W(DLY_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .l2_hit     (l2_hit),
    .l2_retry   (l2_retry),
    .mem_start  (mem_start),
    .l2_claimed (l2_claimed),
    .retried    (retried),
    .cfg_error  (cfg_error),
    .busy       (busy)
);

// File: tb/l2_claim_qual_tb.sv
module l2_claim_qual_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DLY_W      = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_l2_present = 1'b0;
    logic [DLY_W-1:0] cfg_hit_delay = '0;
    logic ts = 1'b0, txn_ci = 1'b0, txn_internal = 1'b0, txn_local_bank = 1'b0;
    logic txn_port64 = 1'b1, txn_pipelined = 1'b0;
    logic l2_hit = 1'b0, l2_retry = 1'b0;
    logic mem_start, l2_claimed, retried, cfg_error, busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    l2_claim_qual #(.DLY_W(DLY_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_l2_present(cfg_l2_present), .cfg_hit_delay(cfg_hit_delay),
        .ts(ts), .txn_ci(txn_ci), .txn_internal(txn_internal), .txn_local_bank(txn_local_bank),
        .txn_port64(txn_port64), .txn_pipelined(txn_pipelined), .l2_hit(l2_hit),
        .l2_retry(l2_retry), .mem_start(mem_start), .l2_claimed(l2_claimed),
        .retried(retried), .cfg_error(cfg_error), .busy(busy)
    );

    // Output vector order: {mem_start, l2_claimed, retried, cfg_error}
    function automatic logic [3:0] outs();
        return {mem_start, l2_claimed, retried, cfg_error};
    endfunction

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle (after the strobe's negedge) in which the verdict is visible.
    function automatic int exp_cycle(input bit present, input bit ci, input bit intl,
                                     input bit lb, input bit p64, input bit pipe, input int d);
        if (!present || ci || intl || lb || !p64 || pipe) return 1;
        return d + 2;
    endfunction

    function automatic logic [3:0] exp_vec(input bit present, input bit ci, input bit intl,
                                           input bit lb, input bit p64, input bit pipe,
                                           input bit hit, input bit retry);
        if (!present || ci || intl || lb) return 4'b1000;
        if (!p64 || pipe)                 return 4'b1001;
        if (retry)                        return 4'b0010;
        if (hit)                          return 4'b0100;
        return 4'b1000;
    endfunction

    function automatic string auto_tag(input bit present, input bit ci, input bit intl,
                                       input bit lb, input bit p64, input bit pipe,
                                       input bit hit, input bit retry);
        if (!present)        return "R1";
        if (ci)              return "R6";
        if (intl || lb)      return "R7";
        if (!p64 || pipe)    return "R8";
        if (retry)           return "R5";
        if (hit)             return "R3";
        return "R4";
    endfunction

    // noise_mode: 0 quiet, 1 random, 2 inverse of sample values
    task automatic run_txn(input bit present, input int d, input bit ci, input bit intl,
                           input bit lb, input bit p64, input bit pipe,
                           input bit hit_s, input bit retry_s, input int noise_mode,
                           input string tag_in);
        int ec;
        logic [3:0] ev;
        string tag;
        ec  = exp_cycle(present, ci, intl, lb, p64, pipe, d);
        ev  = exp_vec(present, ci, intl, lb, p64, pipe, hit_s, retry_s);
        tag = (tag_in == "") ? auto_tag(present, ci, intl, lb, p64, pipe, hit_s, retry_s) : tag_in;
        @(negedge clk);
        cfg_l2_present = present; cfg_hit_delay = DLY_W'(d);
        ts = 1'b1; txn_ci = ci; txn_internal = intl; txn_local_bank = lb;
        txn_port64 = p64; txn_pipelined = pipe;
        l2_hit = (noise_mode == 2) ? !hit_s : (noise_mode == 1) ? 1'($urandom) : 1'b0;
        l2_retry = (noise_mode == 2) ? !retry_s : (noise_mode == 1) ? 1'($urandom) : 1'b0;
        for (int j = 1; j <= 7; j++) begin
            @(negedge clk);
            chk(outs(), (j == ec) ? ev : 4'b0000, tag);
            ts = 1'b0;
            if (j == d + 1) begin
                l2_hit = hit_s; l2_retry = retry_s;
            end else if (noise_mode == 2) begin
                l2_hit = !hit_s; l2_retry = !retry_s;
            end else if (noise_mode == 1) begin
                l2_hit = 1'($urandom); l2_retry = 1'($urandom);
            end else begin
                l2_hit = 1'b0; l2_retry = 1'b0;
            end
        end
        l2_hit = 1'b0; l2_retry = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(outs(), 4'b0000, "R11");
        chk({3'b000, busy}, 4'b0000, "R11");
        rst = 1'b0;

        // R1: cache absent, hit everywhere ignored
        run_txn(0, 2, 0, 0, 0, 1, 0, 1, 0, 2, "R1");
        // R2: sample edge only, inverse noise elsewhere, each delay
        for (int d = 0; d < 4; d++) begin
            run_txn(1, d, 0, 0, 0, 1, 0, 1, 0, 2, "R2");
            run_txn(1, d, 0, 0, 0, 1, 0, 0, 0, 2, "R2");
        end
        run_txn(1, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R3");
        run_txn(1, 3, 0, 0, 0, 1, 0, 0, 0, 0, "R4");
        run_txn(1, 1, 0, 0, 0, 1, 0, 1, 1, 0, "R5");
        run_txn(1, 2, 0, 0, 0, 1, 0, 0, 1, 1, "R5");
        run_txn(1, 1, 1, 0, 0, 1, 0, 1, 0, 2, "R6");
        run_txn(1, 1, 0, 1, 0, 1, 0, 1, 0, 2, "R7");
        run_txn(1, 1, 0, 0, 1, 0, 1, 1, 0, 2, "R7");
        run_txn(1, 1, 0, 0, 0, 0, 0, 1, 0, 2, "R8");
        run_txn(1, 1, 0, 0, 0, 1, 1, 1, 0, 2, "R8");

        // R9: second strobe (caching-inhibited) during a delay-3 window that hits
        @(negedge clk);
        cfg_l2_present = 1; cfg_hit_delay = 2'd3;
        ts = 1; txn_ci = 0; txn_internal = 0; txn_local_bank = 0; txn_port64 = 1; txn_pipelined = 0;
        for (int j = 1; j <= 8; j++) begin
            @(negedge clk);
            chk(outs(), (j == 5) ? 4'b0100 : (j == 6) ? 4'b1000 : 4'b0000, "R9");
            ts = (j == 2);
            txn_ci = (j == 2);
            l2_hit = (j == 4);
        end
        ts = 0; txn_ci = 0; l2_hit = 0;

        // R11: reset during an open window drops it
        @(negedge clk);
        cfg_hit_delay = 2'd3; ts = 1;
        @(negedge clk);
        ts = 0; rst = 1; l2_hit = 0;
        @(negedge clk);
        rst = 0;
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk({outs()[3:1], busy}, 4'b0000, "R11");
        end

        // Random mix (R10 covered by exclusive verdict checks throughout)
        for (int i = 0; i < 400; i++) begin
            bit p, c, n, l, w, q, h, r;
            int d;
            p = ($urandom_range(9) != 0);
            c = ($urandom_range(5) == 0);
            n = ($urandom_range(7) == 0);
            l = ($urandom_range(7) == 0);
            w = ($urandom_range(7) != 0);
            q = ($urandom_range(7) == 0);
            h = 1'($urandom);
            r = ($urandom_range(3) == 0);
            d = int'($urandom_range(3));
            run_txn(p, d, c, n, l, w, q, h, r, 1, "");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule